// File: doc/BRIEF.md
# USB Event Interrupt Aggregator with End-of-Interrupt Gate

This block collects the event lines of a USB controller core and turns them into one interrupt request for a CPU. It takes per-endpoint transmit events, per-endpoint receive events, core-level events and a VBUS-drive level, and latches each event into a 32-bit raw source register. A mask register selects which latched bits may interrupt the CPU. Software reaches both registers only through separate write-one-to-set and write-one-to-clear aliases. A read-only view returns the source bits that pass the mask.

The interrupt output is a one-cycle pulse. After a pulse the output stays low, even while enabled sources are still pending, until software writes the end-of-interrupt register. The write data of that register is ignored. The block also has a revision register that reads a fixed nonzero value, a control register whose bit 0 performs a soft reset, and a status register that shows the synchronized VBUS-drive level. Access is through a simple synchronous register bus. Read data is registered and appears in the cycle after the read strobe.

Register offsets: revision 0x00, control 0x04, status 0x08, source 0x20, source-set 0x24, source-clear 0x28, mask 0x2C, mask-set 0x30, mask-clear 0x34, masked source 0x38, end-of-interrupt 0x3C.

Top module: `usb_irq_aggr`

## Requirements
- R1: After rst_n is released, the source and mask registers read 0 and irq_out is low. The end-of-interrupt gate starts armed, so the first pending masked bit raises irq_out without any end-of-interrupt write.
- R2: A read of offset 0x00 returns the parameter REV_ID (default 32'h0A7E_0101), which must be nonzero.
- R3: In the source register, transmit events sit at bits 0..4 and receive events at bits 9..12. Core events sit at bits 16..24, and every other bit reads 0. A write to 0x24 sets the source bits written as 1. A write to 0x28 clears the source bits written as 1. Bits written as 0 keep their value.
- R4: A write to 0x30 sets the mask bits written as 1, and a write to 0x34 clears them. Bits written as 0 keep their value, and only the bit positions listed in R3 exist in the mask.
- R5: A read of offset 0x38 returns the source register ANDed with the mask register.
- R6: A rising edge on tx_evt[i], rx_evt[j] or core_evt[k] sets source bit i, 9+j or 16+k. If the same bit is cleared through 0x28 in that same cycle, the hardware event wins and the bit stays set.
- R7: Bit 0 of the status register (0x08) is vbus_drv after a synchronizer of VBUS_SYNC stages. Every change of the synchronized level, rising or falling, sets source bit 24.
- R8: While the gate is armed, irq_out rises in the cycle after the masked source becomes nonzero. It stays high for exactly one cycle.
- R9: After a pulse, irq_out stays low until a write to 0x3C, whatever its data. If masked bits are still pending, that write makes irq_out rise one cycle later.
- R10: Writing control (0x04) with bit 0 set clears the source and mask registers, re-arms the gate and drops irq_out.
- R11: Reads of the control register and of any offset not listed return 0.
- R12: bus_rdata changes only at the clock edge that samples bus_rd high. It holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Register byte offset |
| bus_wr | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| tx_evt | input | TX_EPS (5) | Transmit endpoint event lines |
| rx_evt | input | RX_EPS (4) | Receive endpoint event lines, endpoints 1 and up |
| core_evt | input | CORE_EVS-1 (8) | Core-level event lines |
| vbus_drv | input | 1 | VBUS-drive level, asynchronous |
| irq_out | output | 1 | One-cycle interrupt pulse |

## Verification
On every cycle, the embedded properties check that irq_out is a single-cycle pulse and that it never appears while the gate is disarmed. They also check that an end-of-interrupt write re-arms the gate, that set, clear and hardware-set updates land in the source register, and that soft reset empties both registers. They further check that unmapped reads return zero and that read data holds between strobes. Other behaviour needs directed scenarios: a hardware event colliding with a clear of the same bit, VBUS change capture on both edges through the synchronizer, the exact one-cycle delay of the interrupt, and the re-arm after soft reset without an end-of-interrupt write.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
   localparam int REG_W = 32;

   localparam logic [7:0] OFS_REV    = 8'h00;
   localparam logic [7:0] OFS_CTRL   = 8'h04;
   localparam logic [7:0] OFS_STAT   = 8'h08;
   localparam logic [7:0] OFS_SRC    = 8'h20;
   localparam logic [7:0] OFS_SRCSET = 8'h24;
   localparam logic [7:0] OFS_SRCCLR = 8'h28;
   localparam logic [7:0] OFS_MSK    = 8'h2C;
   localparam logic [7:0] OFS_MSKSET = 8'h30;
   localparam logic [7:0] OFS_MSKCLR = 8'h34;
   localparam logic [7:0] OFS_MASKED = 8'h38;
   localparam logic [7:0] OFS_EOI    = 8'h3C;

   // contiguous run of n ones starting at bit lsb
   function automatic logic [REG_W-1:0] field_bits(int lsb, int n);
      logic [REG_W-1:0] m;
      m = '0;
      for (int i = 0; i < REG_W; i++)
         if (i >= lsb && i < lsb + n) m[i] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/uirq_edge_det.sv
module uirq_edge_det #(
   parameter int W           = 1,
   parameter int SYNC_STAGES = 0,
   parameter bit BOTH_EDGES  = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] level,
   output logic [W-1:0] evt
);
   logic [W-1:0] prev_q;

   if (W < 1) begin : g_bad_w
      $error("uirq_edge_det: W must be at least 1");
   end

   if (SYNC_STAGES == 0) begin : g_direct
      assign level = din;
   end else begin : g_sync
      logic [W-1:0] stg_q [SYNC_STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) stg_q[i] <= '0;
         end else begin
            stg_q[0] <= din;
            for (int i = 1; i < SYNC_STAGES; i++) stg_q[i] <= stg_q[i-1];
         end
      end
      assign level = stg_q[SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= level;
   end

   if (BOTH_EDGES) begin : g_any
      assign evt = level ^ prev_q;
   end else begin : g_rise
      assign evt = level & ~prev_q;
   end
endmodule

// File: rtl/uirq_srcmask.sv
module uirq_srcmask #(
   parameter int                       W     = 32,
   parameter logic [W-1:0]             VALID = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sreset,
   input  logic [W-1:0] sw_set,
   input  logic [W-1:0] sw_clr,
   input  logic [W-1:0] hw_set,
   input  logic [W-1:0] msk_set,
   input  logic [W-1:0] msk_clr,
   output logic [W-1:0] src_q,
   output logic [W-1:0] mask_q
);
   logic [W-1:0] src_d, mask_d;

   always_comb begin
      // hardware set overrides a same-cycle software clear
      src_d  = ((src_q | sw_set | hw_set) & ~(sw_clr & ~hw_set)) & VALID;
      mask_d = ((mask_q | msk_set) & ~msk_clr) & VALID;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q  <= '0;
         mask_q <= '0;
      end else if (sreset) begin
         src_q  <= '0;
         mask_q <= '0;
      end else begin
         src_q  <= src_d;
         mask_q <= mask_d;
      end
   end

   a_r3_sw_set_lands : assert property (@(posedge clk) disable iff (!rst_n)
      !sreset |=> ((src_q & $past(sw_set & VALID)) == $past(sw_set & VALID)));
   a_r3_sw_clr_lands : assert property (@(posedge clk) disable iff (!rst_n)
      !sreset |=> ((src_q & $past(sw_clr & ~hw_set & ~sw_set)) == '0));
   a_r6_hw_wins : assert property (@(posedge clk) disable iff (!rst_n)
      !sreset |=> ((src_q & $past(hw_set & VALID)) == $past(hw_set & VALID)));
   a_r4_mask_set : assert property (@(posedge clk) disable iff (!rst_n)
      !sreset |=> ((mask_q & $past(msk_set & ~msk_clr & VALID)) == $past(msk_set & ~msk_clr & VALID)));
   a_r10_sreset_empty : assert property (@(posedge clk) disable iff (!rst_n)
      sreset |=> (src_q == '0 && mask_q == '0));
endmodule

// File: rtl/uirq_eoi_gate.sv
module uirq_eoi_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic sreset,
   input  logic eoi_wr,
   input  logic pending,
   output logic irq
);
   logic armed_q, fire;

   assign fire = armed_q & pending;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b1;
         irq     <= 1'b0;
      end else if (sreset) begin
         armed_q <= 1'b1;
         irq     <= 1'b0;
      end else begin
         irq <= fire;
         if (fire)        armed_q <= 1'b0;
         else if (eoi_wr) armed_q <= 1'b1;
      end
   end

   a_r8_one_cycle_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
   a_r8_fires_when_armed : assert property (@(posedge clk) disable iff (!rst_n)
      armed_q && pending && !sreset |=> irq);
   a_r9_disarmed_after_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> !armed_q);
   a_r9_eoi_rearms : assert property (@(posedge clk) disable iff (!rst_n)
      eoi_wr && !sreset |=> (armed_q || irq));
endmodule

// File: rtl/usb_irq_aggr.sv
module usb_irq_aggr
   import uirq_pkg::*;
#(
   parameter int               ADDR_W    = 8,
   parameter int               TX_EPS    = 5,
   parameter int               RX_EPS    = 4,
   parameter int               CORE_EVS  = 9,
   parameter int               TX_LSB    = 0,
   parameter int               RX_LSB    = 9,
   parameter int               CORE_LSB  = 16,
   parameter int               VBUS_SYNC = 2,
   parameter logic [31:0]      REV_ID    = 32'h0A7E_0101
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_wr,
   input  logic [31:0]         bus_wdata,
   input  logic                bus_rd,
   output logic [31:0]         bus_rdata,
   input  logic [TX_EPS-1:0]   tx_evt,
   input  logic [RX_EPS-1:0]   rx_evt,
   input  logic [CORE_EVS-2:0] core_evt,
   input  logic                vbus_drv,
   output logic                irq_out
);
   localparam int               VBUS_BIT = CORE_LSB + CORE_EVS - 1;
   localparam logic [REG_W-1:0] VALID    = field_bits(TX_LSB, TX_EPS)
                                         | field_bits(RX_LSB, RX_EPS)
                                         | field_bits(CORE_LSB, CORE_EVS);

   // elaboration checks on the field layout
   if (ADDR_W < 6) begin : g_bad_addr
      $error("usb_irq_aggr: ADDR_W too small for the register map");
   end
   if (TX_LSB + TX_EPS > RX_LSB || RX_LSB + RX_EPS > CORE_LSB
       || CORE_LSB + CORE_EVS > REG_W) begin : g_bad_fields
      $error("usb_irq_aggr: event fields overlap or exceed the register");
   end
   if (VBUS_SYNC < 1 || CORE_EVS < 2) begin : g_bad_misc
      $error("usb_irq_aggr: VBUS_SYNC >= 1 and CORE_EVS >= 2 required");
   end
   if (REV_ID == 32'h0) begin : g_bad_rev
      $error("usb_irq_aggr: REV_ID must be nonzero");
   end

   // ---------------- event capture ----------------
   localparam int EV_W = TX_EPS + RX_EPS + CORE_EVS - 1;
   logic [EV_W-1:0] ev_lvl, ev_rise;
   logic            vbus_lvl, vbus_chg;

   uirq_edge_det #(.W(EV_W), .SYNC_STAGES(0), .BOTH_EDGES(1'b0)) u_ev_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({core_evt, rx_evt, tx_evt}),
      .level(ev_lvl),
      .evt  (ev_rise)
   );

   uirq_edge_det #(.W(1), .SYNC_STAGES(VBUS_SYNC), .BOTH_EDGES(1'b1)) u_vbus_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (vbus_drv),
      .level(vbus_lvl),
      .evt  (vbus_chg)
   );

   logic [REG_W-1:0] hw_set;
   always_comb begin
      hw_set = '0;
      for (int i = 0; i < TX_EPS; i++)       hw_set[TX_LSB + i]   = ev_rise[i];
      for (int i = 0; i < RX_EPS; i++)       hw_set[RX_LSB + i]   = ev_rise[TX_EPS + i];
      for (int i = 0; i < CORE_EVS - 1; i++) hw_set[CORE_LSB + i] = ev_rise[TX_EPS + RX_EPS + i];
      hw_set[VBUS_BIT] = vbus_chg;
   end

   // ---------------- register decode ----------------
   function automatic logic hit(logic [ADDR_W-1:0] a, logic [7:0] ofs);
      return a == ADDR_W'(ofs);
   endfunction

   logic             sreset, eoi_wr;
   logic [REG_W-1:0] sw_set, sw_clr, msk_set, msk_clr;

   always_comb begin
      sreset  = bus_wr && hit(bus_addr, OFS_CTRL) && bus_wdata[0];
      eoi_wr  = bus_wr && hit(bus_addr, OFS_EOI);
      sw_set  = (bus_wr && hit(bus_addr, OFS_SRCSET)) ? bus_wdata : '0;
      sw_clr  = (bus_wr && hit(bus_addr, OFS_SRCCLR)) ? bus_wdata : '0;
      msk_set = (bus_wr && hit(bus_addr, OFS_MSKSET)) ? bus_wdata : '0;
      msk_clr = (bus_wr && hit(bus_addr, OFS_MSKCLR)) ? bus_wdata : '0;
   end

   logic [REG_W-1:0] src_q, mask_q, masked;

   uirq_srcmask #(.W(REG_W), .VALID(VALID)) u_srcmask (
      .clk    (clk),
      .rst_n  (rst_n),
      .sreset (sreset),
      .sw_set (sw_set),
      .sw_clr (sw_clr),
      .hw_set (hw_set),
      .msk_set(msk_set),
      .msk_clr(msk_clr),
      .src_q  (src_q),
      .mask_q (mask_q)
   );

   assign masked = src_q & mask_q;

   uirq_eoi_gate u_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .sreset (sreset),
      .eoi_wr (eoi_wr),
      .pending(|masked),
      .irq    (irq_out)
   );

   // ---------------- read path ----------------
   logic [REG_W-1:0] rd_mux;
   logic             rd_mapped;

   always_comb begin
      rd_mux    = '0;
      rd_mapped = 1'b1;
      if      (hit(bus_addr, OFS_REV))    rd_mux = REV_ID;
      else if (hit(bus_addr, OFS_STAT))   rd_mux = {{(REG_W-1){1'b0}}, vbus_lvl};
      else if (hit(bus_addr, OFS_SRC))    rd_mux = src_q;
      else if (hit(bus_addr, OFS_MSK))    rd_mux = mask_q;
      else if (hit(bus_addr, OFS_MASKED)) rd_mux = masked;
      else                                rd_mapped = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
   end

   a_r11_unmapped_zero : assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd && !rd_mapped |=> bus_rdata == '0);
   a_r12_rdata_holds : assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));
   a_r3_no_stray_bits : assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd && hit(bus_addr, OFS_SRC) |=> (bus_rdata & ~VALID) == '0);
   a_r7_status_single_bit : assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd && hit(bus_addr, OFS_STAT) |=> bus_rdata[REG_W-1:1] == '0);
endmodule

// File: tb/usb_irq_aggr_tb.sv
`timescale 1ns/1ps
module usb_irq_aggr_tb;
   localparam logic [31:0] REV   = 32'h0A7E_0101;
   localparam logic [31:0] VALID = 32'h01FF_1E1F;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_rdata;
   logic [4:0]  tx_evt = '0;
   logic [3:0]  rx_evt = '0;
   logic [7:0]  core_evt = '0;
   logic        vbus_drv = 1'b0;
   logic        irq_out;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   usb_irq_aggr u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .tx_evt(tx_evt), .rx_evt(rx_evt), .core_evt(core_evt),
      .vbus_drv(vbus_drv), .irq_out(irq_out)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      check("R1 irq after reset", {31'b0, irq_out}, 32'h0);
      rd(8'h20, v); check("R1 source after reset", v, 32'h0);
      rd(8'h2C, v); check("R1 mask after reset", v, 32'h0);
      rd(8'h00, v); check("R2 revision", v, REV);
      // armed out of reset: first pending masked bit fires without EOI
      wr(8'h30, 32'h1);
      wr(8'h24, 32'h1);
      @(negedge clk);
      check("R1 gate armed from reset", {31'b0, irq_out}, 32'h1);
   endtask

   task automatic t_src_alias();
      logic [31:0] v;
      wr(8'h04, 32'h1);
      wr(8'h24, 32'hFFFF_FFFF);
      rd(8'h20, v); check("R3 set all, only field bits", v, VALID);
      wr(8'h28, 32'h0000_0E01);
      rd(8'h20, v); check("R3 clear subset", v, 32'h01FF_101E);
      rd(8'h38, v); check("R5 masked with zero mask", v, 32'h0);
   endtask

   task automatic t_mask();
      logic [31:0] v;
      wr(8'h04, 32'h1);
      wr(8'h30, 32'h00FF_0F0F);
      rd(8'h2C, v); check("R4 mask set", v, 32'h00FF_0E0F);
      wr(8'h34, 32'h0000_000F);
      rd(8'h2C, v); check("R4 mask clear", v, 32'h00FF_0E00);
      wr(8'h24, 32'h0101_1203);
      rd(8'h38, v); check("R5 masked source", v, 32'h0001_0200);
   endtask

   task automatic t_hw();
      logic [31:0] v;
      wr(8'h04, 32'h1);
      @(negedge clk);
      tx_evt = 5'b00100; rx_evt = 4'b1000; core_evt = 8'h80;
      @(negedge clk);
      tx_evt = '0; rx_evt = '0; core_evt = '0;
      rd(8'h20, v); check("R6 hw event positions", v, 32'h0080_1004);
      wr(8'h24, 32'h3);
      // rising event on bit 1 in the same cycle as a clear of bits 1:0
      @(negedge clk);
      tx_evt = 5'b00010;
      bus_addr = 8'h28; bus_wdata = 32'h3; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; tx_evt = '0;
      rd(8'h20, v); check("R6 hw set beats clear", v, 32'h0080_1006);
   endtask

   task automatic t_vbus();
      logic [31:0] v;
      wr(8'h04, 32'h1);
      vbus_drv = 1'b1;
      repeat (5) @(negedge clk);
      rd(8'h08, v); check("R7 status high", v, 32'h1);
      rd(8'h20, v); check("R7 change on rise", v, 32'h0100_0000);
      wr(8'h28, 32'h0100_0000);
      rd(8'h20, v); check("R7 cleared", v, 32'h0);
      vbus_drv = 1'b0;
      repeat (5) @(negedge clk);
      rd(8'h08, v); check("R7 status low", v, 32'h0);
      rd(8'h20, v); check("R7 change on fall", v, 32'h0100_0000);
   endtask

   task automatic t_irq();
      wr(8'h04, 32'h1);
      wr(8'h30, 32'h0001_0000);
      wr(8'h24, 32'h0001_0000);
      check("R8 no irq in write cycle", {31'b0, irq_out}, 32'h0);
      @(negedge clk);
      check("R8 irq one cycle later", {31'b0, irq_out}, 32'h1);
      @(negedge clk);
      check("R8 pulse ends", {31'b0, irq_out}, 32'h0);
      repeat (6) @(negedge clk);
      check("R9 stays low while pending", {31'b0, irq_out}, 32'h0);
      wr(8'h3C, 32'hDEAD_BEEF);
      check("R9 not yet after EOI", {31'b0, irq_out}, 32'h0);
      @(negedge clk);
      check("R9 re-fires after EOI", {31'b0, irq_out}, 32'h1);
      wr(8'h28, 32'h0001_0000);
      wr(8'h3C, 32'h0);
      repeat (3) @(negedge clk);
      check("R9 EOI with nothing pending", {31'b0, irq_out}, 32'h0);
   endtask

   task automatic t_sreset();
      logic [31:0] v;
      wr(8'h04, 32'h1);
      wr(8'h30, 32'h4);
      wr(8'h24, 32'h4);
      repeat (3) @(negedge clk);
      wr(8'h04, 32'h1);
      rd(8'h20, v); check("R10 source cleared", v, 32'h0);
      rd(8'h2C, v); check("R10 mask cleared", v, 32'h0);
      wr(8'h30, 32'h4);
      wr(8'h24, 32'h4);
      @(negedge clk);
      check("R10 gate re-armed", {31'b0, irq_out}, 32'h1);
      wr(8'h04, 32'h0);
      rd(8'h2C, v); check("R10 ctrl bit0 clear has no effect", v, 32'h4);
   endtask

   task automatic t_unmapped();
      logic [31:0] v;
      rd(8'h0C, v); check("R11 offset 0x0C", v, 32'h0);
      rd(8'h18, v); check("R11 offset 0x18", v, 32'h0);
      rd(8'h44, v); check("R11 offset 0x44", v, 32'h0);
      rd(8'h04, v); check("R11 control reads zero", v, 32'h0);
      // R12: data appears only after the sampling edge
      @(negedge clk);
      bus_addr = 8'h00; bus_rd = 1'b1;
      #0.1;
      check("R12 old data before edge", bus_rdata, 32'h0);
      @(negedge clk);
      bus_rd = 1'b0; bus_addr = 8'h0C;
      check("R12 new data after edge", bus_rdata, REV);
      repeat (2) @(negedge clk);
      check("R12 held without strobe", bus_rdata, REV);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_src_alias();
      t_mask();
      t_hw();
      t_vbus();
      t_irq();
      t_sreset();
      t_unmapped();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule